// File: doc/BRIEF.md
# Program Counter with Effective-Address Generation

This block holds the 16-bit program counter of a small teaching-style processor and computes the effective address that its memory and branch operations need. An address adder adds a base to an offset. The base is either the current PC or the value read from the first source register. The offset is either zero or a sign-extended immediate taken from one of three low fields of the instruction word. The adder result feeds two places. It is one of the next-value choices for the PC, and it is one input of the memory-address multiplexer. The other input of that multiplexer is the low byte of the instruction word, zero-extended, which serves as a vector-table address.

A control sequencer outside the block drives the selects and the PC load enable once per cycle. The PC next value is the incremented PC, the adder result, or the shared bus value, and it is captured on a rising edge only while the load enable is high. The adder result and the address multiplexer output are combinational. They are valid in the same cycle as their inputs, whether or not the PC is loading. The block receives only the low eleven bits of the instruction register, because no higher bit affects any of its results.

Top module: `pcgen_top`

## Requirements
- R1: With the load enable high and PC select 2'b00, the PC becomes PC + 1 at the next rising edge. The increment wraps from 16'hFFFF to 16'h0000.
- R2: With the load enable high and PC select 2'b01, the PC becomes the address-adder result that is present before that edge.
- R3: With the load enable high and PC select 2'b10, the PC becomes the bus value that is present before that edge.
- R4: While the load enable is low, the PC keeps its value whatever the selects, bus and other inputs are.
- R5: PC select 2'b11 is reserved. With the load enable high and this select, the PC keeps its value.
- R6: Reset is synchronous and active high. A rising edge with reset high sets the PC to 16'h0000, and reset takes priority over a load.
- R7: Base select 0 adds to the current PC. Base select 1 adds to the source-register-1 value.
- R8: Offset select 2'b00 adds zero. 2'b01 adds IR[5:0] sign-extended, 2'b10 adds IR[8:0] sign-extended, and 2'b11 adds IR[10:0] sign-extended. The sum wraps modulo 2^16.
- R9: Address-multiplexer select 0 outputs IR[7:0] zero-extended to 16 bits. Select 1 outputs the adder result.
- R10: The adder result and the address-multiplexer output follow their inputs in the same cycle and do not depend on the load enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_field | input | 11 | Instruction register bits [10:0] |
| sr1_val | input | 16 | Value of source register 1 |
| bus_val | input | 16 | Value on the shared bus |
| pc_sel | input | 2 | PC next-value select: 00 increment, 01 adder, 10 bus, 11 reserved |
| ld_pc | input | 1 | PC load enable |
| base_sel | input | 1 | Adder base: 0 PC, 1 source register 1 |
| off_sel | input | 2 | Adder offset: 00 zero, 01/10/11 sign-extended 6/9/11-bit field |
| mar_sel | input | 1 | Address multiplexer: 0 zero-extended IR[7:0], 1 adder result |
| pc_out | output | 16 | Current PC |
| adder_out | output | 16 | Effective-address adder result |
| mar_out | output | 16 | Address multiplexer output |

## Verification
The bench builds the block with its default parameters: a 16-bit word, immediate fields of 6, 9 and 11 bits, and an 8-bit vector field. With these values the wrap at 16'hFFFF is reached in one bus load followed by one increment. Each offset width is exercised with its sign bit both set and clear, so a wrong extension width shows up as a value error. The 11-bit field makes the widest negative offset reachable against a small register base, and the adder's modular wrap follows from that.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;

    localparam int unsigned PCG_WORD_W = 16;
    localparam int unsigned PCG_FLD_W  = 11;

    typedef enum logic [1:0] {
        PCN_INCR  = 2'b00,
        PCN_ADDER = 2'b01,
        PCN_BUS   = 2'b10,
        PCN_RSVD  = 2'b11
    } pc_next_e;

    typedef enum logic {
        BASE_PC  = 1'b0,
        BASE_SR1 = 1'b1
    } base_e;

    typedef enum logic [1:0] {
        OFS_ZERO  = 2'b00,
        OFS_SHORT = 2'b01,
        OFS_MID   = 2'b10,
        OFS_LONG  = 2'b11
    } ofs_e;

    typedef enum logic {
        MAD_VECTOR = 1'b0,
        MAD_ADDER  = 1'b1
    } mad_e;

    typedef struct packed {
        pc_next_e pc_next;
        logic     load;
        base_e    base;
        ofs_e     ofs;
        mad_e     mad;
    } pcg_ctrl_t;

    function automatic pcg_ctrl_t pack_ctrl(
        input logic [1:0] pc_sel,
        input logic       ld,
        input logic       base_sel,
        input logic [1:0] off_sel,
        input logic       mar_sel
    );
        pcg_ctrl_t c;
        c.pc_next = pc_next_e'(pc_sel);
        c.load    = ld;
        c.base    = base_e'(base_sel);
        c.ofs     = ofs_e'(off_sel);
        c.mad     = mad_e'(mar_sel);
        return c;
    endfunction

endpackage

// File: rtl/pcgen_offset_sel.sv
module pcgen_offset_sel
    import pcgen_pkg::*;
#(
    parameter int unsigned W     = PCG_WORD_W,
    parameter int unsigned FLD_W = PCG_FLD_W,
    parameter int unsigned SH_W  = 6,
    parameter int unsigned MD_W  = 9,
    parameter int unsigned LG_W  = 11
) (
    input  logic [FLD_W-1:0] ir_field,
    input  ofs_e             sel,
    output logic [W-1:0]     offset
);
    localparam int unsigned NUM_EXT = 3;

    logic [W-1:0] cand [NUM_EXT+1];

    assign cand[0] = '0;

    for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_ext
        localparam int unsigned FW = (gi == 0) ? SH_W : (gi == 1) ? MD_W : LG_W;
        assign cand[gi+1] = {{(W-FW){ir_field[FW-1]}}, ir_field[FW-1:0]};
    end

    always_comb begin
        offset = cand[sel];
    end

    // R8: the zero choice contributes no offset
    always_comb begin
        if (sel == OFS_ZERO) begin
            assert_zero_ofs_R8: assert (offset == '0);
        end
    end

endmodule

// File: rtl/pcgen_addr_adder.sv
module pcgen_addr_adder
    import pcgen_pkg::*;
#(
    parameter int unsigned W = PCG_WORD_W
) (
    input  logic [W-1:0] pc_val,
    input  logic [W-1:0] sr1_val,
    input  base_e        base,
    input  logic [W-1:0] offset,
    output logic [W-1:0] sum
);
    logic [W-1:0] base_val;

    always_comb begin
        unique case (base)
            BASE_PC:  base_val = pc_val;
            BASE_SR1: base_val = sr1_val;
            default:  base_val = pc_val;
        endcase
        sum = base_val + offset;
    end

endmodule

// File: rtl/pcgen_addr_mux.sv
module pcgen_addr_mux
    import pcgen_pkg::*;
#(
    parameter int unsigned W     = PCG_WORD_W,
    parameter int unsigned VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [W-1:0]     sum,
    input  mad_e             sel,
    output logic [W-1:0]     addr
);
    logic [W-1:0] vec_ext;

    assign vec_ext = {{(W-VEC_W){1'b0}}, vec};

    always_comb begin
        addr = (sel == MAD_ADDER) ? sum : vec_ext;
    end

    // R9: vector choice never has upper bits set
    always_comb begin
        if (sel == MAD_VECTOR) begin
            assert_vec_upper_R9: assert (addr[W-1:VEC_W] == '0);
        end
    end

endmodule

// File: rtl/pcgen_pc_reg.sv
module pcgen_pc_reg
    import pcgen_pkg::*;
#(
    parameter int unsigned W = PCG_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  pc_next_e     sel,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] bus_val,
    output logic [W-1:0] pc_q
);
    logic [W-1:0] pc_nxt;
    logic         take;

    always_comb begin
        unique case (sel)
            PCN_INCR:  pc_nxt = pc_q + W'(1);
            PCN_ADDER: pc_nxt = sum;
            PCN_BUS:   pc_nxt = bus_val;
            default:   pc_nxt = pc_q;
        endcase
        take = load && (sel != PCN_RSVD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (take) begin
            pc_q <= pc_nxt;
        end
    end

    assert_reset_R6: assert property (@(posedge clk)
        rst |=> pc_q == '0);

    assert_incr_R1: assert property (@(posedge clk) disable iff (rst)
        (load && sel == PCN_INCR) |=> pc_q == $past(pc_q) + W'(1));

    assert_adder_R2: assert property (@(posedge clk) disable iff (rst)
        (load && sel == PCN_ADDER) |=> pc_q == $past(sum));

    assert_bus_R3: assert property (@(posedge clk) disable iff (rst)
        (load && sel == PCN_BUS) |=> pc_q == $past(bus_val));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc_q));

    assert_rsvd_R5: assert property (@(posedge clk) disable iff (rst)
        (load && sel == PCN_RSVD) |=> $stable(pc_q));

endmodule

// File: rtl/pcgen_top.sv
module pcgen_top
    import pcgen_pkg::*;
#(
    parameter int unsigned W     = PCG_WORD_W,
    parameter int unsigned SH_W  = 6,
    parameter int unsigned MD_W  = 9,
    parameter int unsigned LG_W  = 11,
    parameter int unsigned VEC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LG_W-1:0] ir_field,
    input  logic [W-1:0]    sr1_val,
    input  logic [W-1:0]    bus_val,
    input  logic [1:0]      pc_sel,
    input  logic            ld_pc,
    input  logic            base_sel,
    input  logic [1:0]      off_sel,
    input  logic            mar_sel,
    output logic [W-1:0]    pc_out,
    output logic [W-1:0]    adder_out,
    output logic [W-1:0]    mar_out
);
    pcg_ctrl_t    ctl;
    logic [W-1:0] pc_q;
    logic [W-1:0] ofs_val;
    logic [W-1:0] sum;

    assign ctl = pack_ctrl(pc_sel, ld_pc, base_sel, off_sel, mar_sel);

    pcgen_offset_sel #(
        .W(W), .FLD_W(LG_W), .SH_W(SH_W), .MD_W(MD_W), .LG_W(LG_W)
    ) u_ofs (
        .ir_field (ir_field),
        .sel      (ctl.ofs),
        .offset   (ofs_val)
    );

    pcgen_addr_adder #(.W(W)) u_add (
        .pc_val  (pc_q),
        .sr1_val (sr1_val),
        .base    (ctl.base),
        .offset  (ofs_val),
        .sum     (sum)
    );

    pcgen_addr_mux #(.W(W), .VEC_W(VEC_W)) u_mux (
        .vec  (ir_field[VEC_W-1:0]),
        .sum  (sum),
        .sel  (ctl.mad),
        .addr (mar_out)
    );

    pcgen_pc_reg #(.W(W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .sel     (ctl.pc_next),
        .sum     (sum),
        .bus_val (bus_val),
        .pc_q    (pc_q)
    );

    assign pc_out    = pc_q;
    assign adder_out = sum;

    // R10: mux follows adder in the same cycle when routed to it
    always_comb begin
        if (mar_sel) begin
            assert_mux_follow_R10: assert (mar_out == adder_out);
        end
    end

endmodule

// File: tb/pcgen_top_bench.sv
`timescale 1ns/1ps
module pcgen_top_bench;

    typedef struct {
        logic        chk_pc;
        logic [15:0] pc;
        logic [15:0] add;
        logic [15:0] mar;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] ir_field = '0;
    logic [15:0] sr1_val = '0;
    logic [15:0] bus_val = '0;
    logic [1:0]  pc_sel = 2'b00;
    logic        ld_pc = 1'b0;
    logic        base_sel = 1'b1;
    logic [1:0]  off_sel = 2'b00;
    logic        mar_sel = 1'b0;
    logic [15:0] pc_out, adder_out, mar_out;

    int          n_run = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [15:0] m_pc = '0;
    logic        m_ok = 1'b0;
    exp_t        sb[$];

    always #4 clk = ~clk;

    pcgen_top u_pcgen_top (
        .clk(clk), .rst(rst), .ir_field(ir_field), .sr1_val(sr1_val),
        .bus_val(bus_val), .pc_sel(pc_sel), .ld_pc(ld_pc), .base_sel(base_sel),
        .off_sel(off_sel), .mar_sel(mar_sel), .pc_out(pc_out),
        .adder_out(adder_out), .mar_out(mar_out)
    );

    function automatic logic [15:0] ext_ofs(input logic [1:0] os, input logic [10:0] ir);
        case (os)
            2'b01:   return {{10{ir[5]}}, ir[5:0]};
            2'b10:   return {{7{ir[8]}}, ir[8:0]};
            2'b11:   return {{5{ir[10]}}, ir[10:0]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [10:0] ir, input logic [15:0] s1,
                        input logic [15:0] bv, input logic [1:0] ps, input logic ld,
                        input logic bs, input logic [1:0] os, input logic ms,
                        input string req);
        exp_t e;
        logic [15:0] base;
        @(negedge clk);
        rst = r; ir_field = ir; sr1_val = s1; bus_val = bv; pc_sel = ps;
        ld_pc = ld; base_sel = bs; off_sel = os; mar_sel = ms;
        base     = bs ? s1 : m_pc;
        e.chk_pc = m_ok;
        e.pc     = m_pc;
        e.add    = base + ext_ofs(os, ir);
        e.mar    = ms ? e.add : {8'h00, ir[7:0]};
        e.req    = req;
        sb.push_back(e);
        if (r) begin
            m_pc = 16'h0000;
            m_ok = 1'b1;
        end else if (ld) begin
            case (ps)
                2'b00:   m_pc = m_pc + 16'h0001;
                2'b01:   m_pc = e.add;
                2'b10:   m_pc = bv;
                default: m_pc = m_pc;
            endcase
        end
    endtask

    // monitor: pop expected items and compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.chk_pc) cmp(e.req, "pc_out", pc_out, e.pc);
                cmp(e.req, "adder_out", adder_out, e.add);
                cmp(e.req, "mar_out", mar_out, e.mar);
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R6 reset, base from sr1 so the unknown PC is not used
        step(1, 11'h000, 16'h1234, 16'h0, 2'b00, 1, 1, 2'b00, 1, "R6");
        step(0, 11'h000, 16'h0000, 16'h0, 2'b00, 0, 0, 2'b00, 0, "R6");
        // R1 increments
        step(0, 11'h000, 16'h0000, 16'h0, 2'b00, 1, 0, 2'b00, 1, "R1");
        step(0, 11'h000, 16'h0000, 16'h0, 2'b00, 1, 0, 2'b00, 1, "R1");
        // R2/R8: PC + sext(6'h3F) = PC - 1
        step(0, 11'h03F, 16'h0000, 16'h0, 2'b01, 1, 0, 2'b01, 1, "R2");
        step(0, 11'h01F, 16'h0000, 16'h0, 2'b01, 1, 0, 2'b01, 1, "R8");
        // R7/R8: sr1 base with 9-bit positive and negative fields
        step(0, 11'h0FF, 16'h4000, 16'h0, 2'b01, 1, 1, 2'b10, 1, "R7");
        step(0, 11'h100, 16'h4000, 16'h0, 2'b01, 0, 1, 2'b10, 1, "R8");
        // R8: 11-bit negative offset wraps below zero
        step(0, 11'h400, 16'h0100, 16'h0, 2'b01, 1, 1, 2'b11, 1, "R8");
        step(0, 11'h3FF, 16'h0001, 16'h0, 2'b00, 0, 1, 2'b11, 1, "R8");
        // R3 bus load then R1 wrap
        step(0, 11'h000, 16'h0000, 16'hFFFF, 2'b10, 1, 0, 2'b00, 0, "R3");
        step(0, 11'h000, 16'h0000, 16'h0000, 2'b00, 1, 0, 2'b00, 0, "R1");
        step(0, 11'h000, 16'h0000, 16'h5A5A, 2'b10, 1, 0, 2'b00, 0, "R3");
        // R4 hold with load low under varied selects
        step(0, 11'h2AA, 16'h7777, 16'h1111, 2'b10, 0, 0, 2'b01, 1, "R4");
        step(0, 11'h155, 16'h7777, 16'h2222, 2'b01, 0, 1, 2'b11, 0, "R4");
        step(0, 11'h000, 16'h0000, 16'h3333, 2'b00, 0, 0, 2'b00, 1, "R4");
        // R5 reserved select with load
        step(0, 11'h000, 16'h0000, 16'h9999, 2'b11, 1, 0, 2'b01, 1, "R5");
        step(0, 11'h000, 16'h0000, 16'h9999, 2'b11, 1, 0, 2'b00, 1, "R5");
        // R9 vector path, upper IR bits must not leak
        step(0, 11'h7AB, 16'hFFFF, 16'h0, 2'b00, 0, 1, 2'b11, 0, "R9");
        step(0, 11'h0FF, 16'hFFFF, 16'h0, 2'b00, 0, 1, 2'b11, 1, "R9");
        // R10 combinational outputs track inputs with load low and high
        step(0, 11'h005, 16'h0010, 16'h0, 2'b00, 0, 1, 2'b01, 1, "R10");
        step(0, 11'h006, 16'h0020, 16'h0, 2'b00, 1, 1, 2'b01, 1, "R10");
        // R6 reset wins over a load
        step(1, 11'h000, 16'h0000, 16'hABCD, 2'b10, 1, 0, 2'b00, 1, "R6");
        step(0, 11'h000, 16'h0000, 16'h0, 2'b00, 0, 0, 2'b00, 1, "R6");
        step(0, 11'h000, 16'h0000, 16'h0, 2'b00, 0, 0, 2'b00, 1, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule